// File: doc/BRIEF.md
# Flash Page Access Guard

This block sits between a processor's memory port and a flash array. It holds a small memory-configuration register that only privileged software may write. It also classifies every flash page access against the chip size that the register selects. A 2-bit size code fixes the highest page of the part. The special page sets are all placed in the top 64-page region, and they move with the size code:
- the boot page is the top page;
- the certificate page is the page just below it;
- a privileged set is formed by two groups of four pages;
- an immutable set is formed by one of those groups plus the top page.

Each access carries a page number, a kind (read, write or fetch) and the byte coming back from the array. One cycle later the guard gives its verdict:
- a read of the certificate page returns all ones and is flagged as censored;
- a write is blocked while flash is locked, and a write to an immutable page is blocked at all times.

The guard keeps the flash-unlock state itself. It remembers whether the most recent instruction fetch came from a privileged page, and it honours an unlock request only when that is so. An explicit lock request always relocks. Blocked writes and refused unlock requests each raise a one-cycle violation pulse, so that the surrounding system can react.

Top module: `flash_page_guard`

## Requirements
- R1: After reset the configuration register reads 0x00, flash is locked, the fetch-privilege flag is clear, and `rd_censor`, `wr_block`, `viol` and `rdata_out` are all zero.
- R2: A configuration write with `cfg_we` and `cfg_priv` both high stores bits 0, 1, 4 and 5 of `cfg_wdata`. From the following cycle, bits 2, 3, 6 and 7 of `cfg_rdata` always read zero.
- R3: A configuration write with `cfg_priv` low leaves `cfg_rdata` unchanged.
- R4: The size code is `cfg_rdata[1:0]`. Codes 0, 1, 2 and 3 give top pages 0x03F, 0x07F, 0x0FF and 0x1FF. Page-number bits above the top page are cleared before classification. The top region consists of the 64 pages ending at the top page, and its offsets are 0x00 to 0x3F.
- R5: A read (`acc_kind`=0) of region offset 0x3E sets `rd_censor` one cycle later, and `rdata_out` is 0xFF in that same cycle. Region offset 0x3E is the certificate page, one below the top page.
- R6: A write (`acc_kind`=1) presented while `flash_unlocked` is low sets `wr_block` one cycle later.
- R7: A write to region offsets 0x2C to 0x2F or 0x3F sets `wr_block` one cycle later, even when flash is unlocked. A write to any other page while unlocked is not blocked.
- R8: A fetch (`acc_kind`=2) updates `unlock_ok` on the next cycle. `unlock_ok` goes high when the fetched page is at region offset 0x2C to 0x2F or 0x3C to 0x3F, and low for any other page. `unlock_req` without `lock_req` sets `flash_unlocked` at the next edge only when `unlock_ok` is high at that edge.
- R9: `lock_req` clears `flash_unlocked` at the next edge, and it takes priority over a simultaneous `unlock_req`.
- R10: `viol` is high for exactly the cycle after each blocked write. It is also high for exactly the cycle after each `unlock_req` that is refused, meaning `unlock_ok` is low and `lock_req` is low.
- R11: One cycle after a read of any page other than the certificate page, or after any fetch, `rdata_out` equals the `acc_rdata_in` that was presented. It is zero after a write, after an idle cycle, or after `acc_kind`=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration register write strobe |
| cfg_priv | input | 1 | Write comes from a privileged context |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration register contents |
| acc_valid | input | 1 | Flash access present this cycle |
| acc_kind | input | 2 | 0 read, 1 write, 2 fetch, 3 none |
| acc_page | input | 9 | Flash page number of the access |
| acc_rdata_in | input | 8 | Byte returned by the flash array |
| lock_req | input | 1 | Relock flash |
| unlock_req | input | 1 | Request flash unlock |
| rdata_out | output | 8 | Guarded read/fetch data |
| rd_censor | output | 1 | Previous read hit the certificate page |
| wr_block | output | 1 | Previous write was blocked |
| viol | output | 1 | One-cycle protection violation pulse |
| unlock_ok | output | 1 | Most recent fetch came from a privileged page |
| flash_unlocked | output | 1 | Flash unlock state |

## Verification
Every result of this guard appears exactly one clock edge after its cause:
- the access verdicts and guarded data come one edge after the access;
- `cfg_rdata` comes one edge after a write;
- `unlock_ok` comes one edge after a fetch;
- `flash_unlocked` comes one edge after a request.

Two chains take longer. A fetch followed by an unlock needs two edges before `flash_unlocked` rises. A configuration write changes classification only for accesses presented after the edge that stores it. The bench drives on the falling edge. Its reference model advances by one edge after each drive, and every output is compared at the next falling edge, so each check lands in the cycle where its result is due.

// File: rtl/fpg_pkg.sv
package fpg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_NONE  = 2'd3
    } acc_kind_e;

    typedef struct packed {
        logic boot;
        logic cert;
        logic priv;
        logic immut;
    } page_class_t;

endpackage

// File: rtl/fpg_page_classify.sv
module fpg_page_classify #(
    parameter int PAGE_W   = 9,
    parameter int REGION_W = 6,
    parameter int SIZE_W   = 2
) (
    input  logic [SIZE_W-1:0]   size_code,
    input  logic [PAGE_W-1:0]   page,
    output fpg_pkg::page_class_t pclass
);
    localparam int OFS_MAX  = (1 << REGION_W) - 1;
    localparam int OFS_CERT = OFS_MAX - 1;
    localparam int GRP_LO   = (OFS_MAX - 19) >> 2;
    localparam int GRP_HI   = (OFS_MAX - 3) >> 2;
    localparam int HI_W     = PAGE_W - REGION_W;

    logic [PAGE_W-1:0]   top_mask;
    logic [PAGE_W-1:0]   pg;
    logic [REGION_W-1:0] ofs;
    logic                in_top;
    logic                grp_lo_hit;
    logic                grp_hi_hit;

    always_comb begin
        top_mask = '0;
        for (int i = 0; i < PAGE_W; i++) begin
            if (i < REGION_W + int'(size_code)) begin
                top_mask[i] = 1'b1;
            end
        end
        pg     = page & top_mask;
        ofs    = pg[REGION_W-1:0];
        in_top = (pg[PAGE_W-1:REGION_W] == top_mask[PAGE_W-1:REGION_W]);

        grp_lo_hit = (ofs[REGION_W-1:2] == (REGION_W-2)'(GRP_LO));
        grp_hi_hit = (ofs[REGION_W-1:2] == (REGION_W-2)'(GRP_HI));

        pclass.boot  = in_top && (ofs == REGION_W'(OFS_MAX));
        pclass.cert  = in_top && (ofs == REGION_W'(OFS_CERT));
        pclass.priv  = in_top && (grp_lo_hit || grp_hi_hit);
        pclass.immut = in_top && (grp_lo_hit || (ofs == REGION_W'(OFS_MAX)));
    end

    logic unused_hi;
    assign unused_hi = ^HI_W;

endmodule

// File: rtl/fpg_cfg_reg.sv
module fpg_cfg_reg #(
    parameter int          DATA_W    = 8,
    parameter int          SIZE_W    = 2,
    parameter logic [7:0]  KEEP_MASK = 8'h33
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_priv,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] cfg,
    output logic [SIZE_W-1:0] size_code
);
    localparam logic [DATA_W-1:0] KEEP = DATA_W'(KEEP_MASK);

    typedef struct packed {
        logic [DATA_W-1:0] cfg;
    } cfg_state_t;

    cfg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_priv) begin
            st_d.cfg = wr_data & KEEP;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg       = st_q.cfg;
    assign size_code = st_q.cfg[SIZE_W-1:0];

endmodule

// File: rtl/fpg_unlock_ctrl.sv
module fpg_unlock_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic fetch_seen,
    input  logic fetch_priv,
    input  logic lock_req,
    input  logic unlock_req,
    output logic unlocked,
    output logic exec_priv,
    output logic refused
);
    typedef struct packed {
        logic unlocked;
        logic exec_priv;
    } unl_state_t;

    unl_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        refused = 1'b0;
        if (lock_req) begin
            st_d.unlocked = 1'b0;
        end else if (unlock_req) begin
            if (st_q.exec_priv) begin
                st_d.unlocked = 1'b1;
            end else begin
                refused = 1'b1;
            end
        end
        if (fetch_seen) begin
            st_d.exec_priv = fetch_priv;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign unlocked  = st_q.unlocked;
    assign exec_priv = st_q.exec_priv;

endmodule

// File: rtl/flash_page_guard.sv
module flash_page_guard #(
    parameter int PAGE_W   = 9,
    parameter int REGION_W = 6,
    parameter int SIZE_W   = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic              cfg_priv,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              acc_valid,
    input  logic [1:0]        acc_kind,
    input  logic [PAGE_W-1:0] acc_page,
    input  logic [DATA_W-1:0] acc_rdata_in,
    input  logic              lock_req,
    input  logic              unlock_req,
    output logic [DATA_W-1:0] rdata_out,
    output logic              rd_censor,
    output logic              wr_block,
    output logic              viol,
    output logic              unlock_ok,
    output logic              flash_unlocked
);
    import fpg_pkg::*;

    localparam logic [DATA_W-1:0] CENSOR_FILL = '1;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              censor;
        logic              block;
        logic              viol;
    } acc_out_t;

    logic [SIZE_W-1:0] size_code;
    page_class_t       pclass;
    acc_kind_e         kind;
    logic              is_read, is_write, is_fetch;
    logic              refused;
    acc_out_t          out_d, out_q;

    fpg_cfg_reg #(
        .DATA_W (DATA_W),
        .SIZE_W (SIZE_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_priv   (cfg_priv),
        .wr_data   (cfg_wdata),
        .cfg       (cfg_rdata),
        .size_code (size_code)
    );

    fpg_page_classify #(
        .PAGE_W   (PAGE_W),
        .REGION_W (REGION_W),
        .SIZE_W   (SIZE_W)
    ) u_cls (
        .size_code (size_code),
        .page      (acc_page),
        .pclass    (pclass)
    );

    assign kind     = acc_kind_e'(acc_kind);
    assign is_read  = acc_valid && (kind == ACC_READ);
    assign is_write = acc_valid && (kind == ACC_WRITE);
    assign is_fetch = acc_valid && (kind == ACC_FETCH);

    fpg_unlock_ctrl u_unl (
        .clk        (clk),
        .rst_n      (rst_n),
        .fetch_seen (is_fetch),
        .fetch_priv (pclass.priv),
        .lock_req   (lock_req),
        .unlock_req (unlock_req),
        .unlocked   (flash_unlocked),
        .exec_priv  (unlock_ok),
        .refused    (refused)
    );

    always_comb begin
        out_d        = '0;
        out_d.censor = is_read && pclass.cert;
        if (is_read || is_fetch) begin
            out_d.rdata = out_d.censor ? CENSOR_FILL : acc_rdata_in;
        end
        out_d.block = is_write && (!flash_unlocked || pclass.immut);
        out_d.viol  = out_d.block || refused;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata_out = out_q.rdata;
    assign rd_censor = out_q.censor;
    assign wr_block  = out_q.block;
    assign viol      = out_q.viol;

    logic unused_boot;
    assign unused_boot = pclass.boot;

endmodule

// File: rtl/fpg_guard_chk.sv
module fpg_guard_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic              cfg_priv,
    input logic [DATA_W-1:0] cfg_rdata,
    input logic              acc_valid,
    input logic [1:0]        acc_kind,
    input logic              lock_req,
    input logic [DATA_W-1:0] rdata_out,
    input logic              rd_censor,
    input logic              wr_block,
    input logic              viol,
    input logic              unlock_ok,
    input logic              flash_unlocked
);
    AST_RSVD_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[3:2] == 2'b00) && (cfg_rdata[7:6] == 2'b00)); // R2

    AST_USER_CFG_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_priv) |=> $stable(cfg_rdata)); // R3

    AST_CENSOR_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_censor |-> (rdata_out == '1)); // R5

    AST_LOCKED_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_kind == 2'd1 && !flash_unlocked) |=> wr_block); // R6

    AST_UNLOCK_NEEDS_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash_unlocked) |-> $past(unlock_ok)); // R8

    AST_LOCK_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |=> !flash_unlocked); // R9

    AST_BLOCK_RAISES_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_block |-> viol); // R10

endmodule

bind flash_page_guard fpg_guard_chk #(.DATA_W(DATA_W)) u_guard_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_we         (cfg_we),
    .cfg_priv       (cfg_priv),
    .cfg_rdata      (cfg_rdata),
    .acc_valid      (acc_valid),
    .acc_kind       (acc_kind),
    .lock_req       (lock_req),
    .rdata_out      (rdata_out),
    .rd_censor      (rd_censor),
    .wr_block       (wr_block),
    .viol           (viol),
    .unlock_ok      (unlock_ok),
    .flash_unlocked (flash_unlocked)
);

// File: tb/flash_page_guard_bench.sv
module flash_page_guard_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cfg_we, cfg_priv;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       acc_valid;
    logic [1:0] acc_kind;
    logic [8:0] acc_page;
    logic [7:0] acc_rdata_in, rdata_out;
    logic       lock_req, unlock_req;
    logic       rd_censor, wr_block, viol, unlock_ok, flash_unlocked;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    // reference model state (value expected after the most recent edge)
    int m_cfg, m_unl, m_ep, m_cen, m_blk, m_viol, m_rd;
    int blk_tag_imm;

    always #2 clk = ~clk;

    flash_page_guard u_flash_page_guard (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_priv(cfg_priv), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_page(acc_page),
        .acc_rdata_in(acc_rdata_in), .lock_req(lock_req), .unlock_req(unlock_req),
        .rdata_out(rdata_out), .rd_censor(rd_censor), .wr_block(wr_block), .viol(viol),
        .unlock_ok(unlock_ok), .flash_unlocked(flash_unlocked)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("R2/R3 cfg_rdata", int'(cfg_rdata), m_cfg);
        chk("R8/R9 flash_unlocked", int'(flash_unlocked), m_unl);
        chk("R8 unlock_ok", int'(unlock_ok), m_ep);
        chk("R5 rd_censor", int'(rd_censor), m_cen);
        chk(blk_tag_imm != 0 ? "R7 wr_block" : "R6 wr_block", int'(wr_block), m_blk);
        chk("R10 viol", int'(viol), m_viol);
        chk("R11/R5 rdata_out", int'(rdata_out), m_rd);
    endtask

    // advance the model by one edge using the currently driven inputs
    task automatic model_step();
        int mask, base, pg, ofs, intop, cert, priv, imm, blk, rej;
        mask  = (64 << (m_cfg & 3)) - 1;                       // R4
        pg    = int'(acc_page) & mask;
        base  = mask - 63;
        intop = (pg >= base);
        ofs   = pg - base;
        cert  = intop && (ofs == 8'h3E);
        priv  = intop && ((ofs >= 8'h2C && ofs <= 8'h2F) || ofs >= 8'h3C);
        imm   = intop && ((ofs >= 8'h2C && ofs <= 8'h2F) || ofs == 8'h3F);
        m_cen = (acc_valid && acc_kind == 2'd0 && cert) ? 1 : 0;
        if (acc_valid && (acc_kind == 2'd0 || acc_kind == 2'd2))
            m_rd = m_cen ? 8'hFF : int'(acc_rdata_in);
        else
            m_rd = 0;
        blk = (acc_valid && acc_kind == 2'd1 && (m_unl == 0 || imm)) ? 1 : 0;
        blk_tag_imm = (m_unl != 0) ? 1 : 0;
        rej = (unlock_req && !lock_req && m_ep == 0) ? 1 : 0;
        m_blk  = blk;
        m_viol = (blk || rej) ? 1 : 0;
        if (lock_req) m_unl = 0;
        else if (unlock_req && m_ep != 0) m_unl = 1;
        if (acc_valid && acc_kind == 2'd2) m_ep = priv;
        if (cfg_we && cfg_priv) m_cfg = int'(cfg_wdata) & 8'h33;
    endtask

    function automatic logic [8:0] pick_page(input int sz);
        int mask, r, ofs;
        mask = (64 << sz) - 1;
        r = $urandom % 10;
        case (r)
            0, 1: return 9'($urandom);
            2:    ofs = 8'h3E;
            3:    ofs = 8'h3F;
            4:    ofs = 8'h2C + ($urandom % 4);
            5:    ofs = 8'h3C + ($urandom % 4);
            default: ofs = $urandom % 64;
        endcase
        // add stray bits above the chip size to exercise masking (R4)
        return 9'(((mask - 63) + ofs) | (($urandom % 512) & ~mask));
    endfunction

    task automatic idle_inputs();
        cfg_we = 0; cfg_priv = 0; cfg_wdata = 0;
        acc_valid = 0; acc_kind = 0; acc_page = 0; acc_rdata_in = 0;
        lock_req = 0; unlock_req = 0;
    endtask

    // one cycle: compare outputs due now, drive next stimulus, advance model
    task automatic cycle();
        @(negedge clk);
        compare_all();
        model_step();
    endtask

    initial begin
        rst_n = 0;
        idle_inputs();
        m_cfg = 0; m_unl = 0; m_ep = 0; m_cen = 0; m_blk = 0; m_viol = 0; m_rd = 0;
        blk_tag_imm = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 cfg_rdata", int'(cfg_rdata), 0);
        chk("R1 flash_unlocked", int'(flash_unlocked), 0);
        chk("R1 unlock_ok", int'(unlock_ok), 0);
        chk("R1 rd_censor", int'(rd_censor), 0);
        chk("R1 wr_block", int'(wr_block), 0);
        chk("R1 viol", int'(viol), 0);
        chk("R1 rdata_out", int'(rdata_out), 0);

        // directed: R2 reserved bits, R3 user write ignored
        cfg_we = 1; cfg_priv = 1; cfg_wdata = 8'hFF; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); cfg_we = 1; cfg_priv = 0; cfg_wdata = 8'h00; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); cfg_we = 1; cfg_priv = 1; cfg_wdata = 8'h00; model_step();

        // directed R5/R7/R8: size 0, certificate read, privileged fetch, unlock, immutable write
        @(negedge clk); compare_all();
        idle_inputs(); acc_valid = 1; acc_kind = 0; acc_page = 9'h03E; acc_rdata_in = 8'h5A; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); acc_valid = 1; acc_kind = 2; acc_page = 9'h02D; acc_rdata_in = 8'hC3; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); unlock_req = 1; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); acc_valid = 1; acc_kind = 1; acc_page = 9'h03F; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); acc_valid = 1; acc_kind = 1; acc_page = 9'h010; model_step();
        @(negedge clk); compare_all();
        idle_inputs(); lock_req = 1; unlock_req = 1; model_step();   // R9 lock wins
        @(negedge clk); compare_all();
        idle_inputs(); model_step();

        // randomized sequences, compared on every clock
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            compare_all();
            idle_inputs();
            if ($urandom % 16 == 0) begin
                cfg_we = 1; cfg_priv = ($urandom % 4) != 0; cfg_wdata = 8'($urandom);
            end
            if ($urandom % 4 != 0) begin
                acc_valid = 1;
                acc_kind = 2'($urandom % 8 == 0 ? 3 : $urandom % 3);
                acc_page = pick_page(m_cfg & 3);
                acc_rdata_in = 8'($urandom);
            end
            lock_req   = ($urandom % 12) == 0;
            unlock_req = ($urandom % 5) == 0;
            model_step();
        end
        @(negedge clk);
        compare_all();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule